// File: doc/BRIEF.md
# Block-Polyphase 5/3 Rational Interpolator

This block raises the sample rate of a signed stream by the ratio 5/3. Incoming samples are gathered three at a time into a block. Each completed block drives a 5-output by 3-input matrix of short FIR sub-filters that run once per block. The matrix is the transpose of the matching 3/5 decimator's matrix. Each sub-filter keeps its history as partial sums (transposed form), so all arithmetic runs at the block rate, Fi/3 = Fo/5. The five block results are rounded, saturated and then sent out one per clock in phase order.

The result is the same as inserting four zeros after every input sample, filtering with a 23-tap FIR and keeping every third sample. The sub-filters hold no zero multiplies. The gain that an interpolation by 5 over 3 needs is part of the coefficient parameter. Upstream logic marks each sample with a valid strobe. It must space blocks so that a block completes no sooner than five cycles after the previous one. Running flat out, that is three samples in every five cycles.

Top module: `blkpoly_interp`

## Requirements
- R1: After reset, and in every cycle where `out_valid` is low, `out_data` is zero. Reset clears all history, so samples from before reset count as zero.
- R2: The cycle after the edge that accepts the third sample of a block, `out_valid` goes high for exactly five consecutive cycles. It is never high at any other time.
- R3: Input samples x[i] are numbered from reset. Block k holds x[3k..3k+2]. Its five outputs are y[5k+l] for l = 0..4, where y[n] is the sum over i of x[i]*h[3n-5i], taken over 0 <= 3n-5i <= 22. Here h[j] is bits [16j+15:16j] of the coefficient parameter, as signed Q1.14.
- R4: Cycles with `in_valid` low are ignored. Idle gaps of any length between samples do not change any output value, and they cannot start an output burst.
- R5: Each sum is scaled down by 2^14 with round to nearest, ties toward plus infinity: (acc + 2^13) >> 14, as an arithmetic shift.
- R6: A rounded value above 32767 is output as 32767. A value below -32768 is output as -32768.
- R7: Within a burst, the outputs leave in phase order l = 0, 1, 2, 3, 4 on consecutive cycles.
- R8: A reset in the middle of a block discards the partial block. The next three accepted samples form block 0, with zero history.
- R9: With blocks completing exactly five cycles apart, bursts join into a gap-free output stream and no result is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 16 | Signed output sample, zero when idle |

## Verification
The hardest case to reach from the ports is a new block that completes in the same cycle the previous burst sends its last phase. At that edge the serializer must reload while it drains, and the transposed partial sums must carry over without a gap. The stimulus gets there by delaying only those samples that would close a block too early. A run with no idle cycles of its own therefore settles into a block every five cycles. Ties in rounding come from isolated samples of ±128 that fall on the centre tap. Saturation comes from long runs at full scale, using a coefficient set whose gain exceeds one.

// File: rtl/blkpoly_pkg.sv
package blkpoly_pkg;
  localparam int DEF_NTAPS = 23;
  localparam int DEF_CW    = 16;

  // Symmetric default set: quadratic taper around the centre tap, Q1.14,
  // gain of the 5/3 interpolation already folded in.
  function automatic logic [DEF_NTAPS*DEF_CW-1:0] default_taps();
    logic [DEF_NTAPS*DEF_CW-1:0] r;
    int d;
    r = '0;
    for (int k = 0; k < DEF_NTAPS; k++) begin
      d = k - (DEF_NTAPS - 1) / 2;
      r[k*DEF_CW +: DEF_CW] = DEF_CW'(5400 - 44 * d * d);
    end
    return r;
  endfunction
endpackage

// File: rtl/blkpoly_blocker.sv
module blkpoly_blocker #(
  parameter int M  = 3,
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 blk_fire,
  output logic signed [DW-1:0] blk_o [M]
);
  localparam int PW = (M > 2) ? $clog2(M) : 1;

  logic [PW-1:0]        phase;
  logic signed [DW-1:0] xr [M-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      for (int j = 0; j < M-1; j++) xr[j] <= '0;
    end else if (in_valid) begin
      if (phase == PW'(M-1)) phase <= '0;
      else                   phase <= phase + 1'b1;
      for (int j = 0; j < M-1; j++)
        if (phase == PW'(j)) xr[j] <= in_data;
    end
  end

  assign blk_fire = in_valid && (phase == PW'(M-1));

  for (genvar m = 0; m < M; m++) begin : g_port
    if (m < M-1) begin : g_held
      assign blk_o[m] = xr[m];
    end else begin : g_live
      assign blk_o[m] = in_data;
    end
  end
endmodule

// File: rtl/blkpoly_matrix.sv
module blkpoly_matrix #(
  parameter int L     = 5,
  parameter int M     = 3,
  parameter int NTAPS = 23,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int AW    = DW + CW + 4,
  parameter logic [NTAPS*CW-1:0] TAPS = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fire,
  input  logic signed [DW-1:0] blk_i [M],
  output logic signed [AW-1:0] acc_o [L]
);
  // Number of block-delay stages any sub-filter spans.
  localparam int ND = (NTAPS - 1 + L * (M - 1)) / (L * M) + 1;

  logic signed [AW-1:0] prod [L][ND][M];
  logic signed [AW-1:0] psum [L][ND];
  logic signed [AW-1:0] st   [L][ND-1];

  for (genvar l = 0; l < L; l++) begin : g_out
    for (genvar d = 0; d < ND; d++) begin : g_dly
      for (genvar m = 0; m < M; m++) begin : g_in
        localparam int IDX = L * M * d + M * l - L * m;
        if (IDX >= 0 && IDX < NTAPS) begin : g_tap
          localparam logic signed [CW-1:0] TV = TAPS[IDX*CW +: CW];
          assign prod[l][d][m] = AW'(blk_i[m]) * AW'(TV);
        end else begin : g_none
          assign prod[l][d][m] = '0;
        end
      end

      always_comb begin
        psum[l][d] = '0;
        for (int m = 0; m < M; m++) psum[l][d] = psum[l][d] + prod[l][d][m];
      end

      // Transposed-form partial-sum registers, one per later block.
      if (d >= 1) begin : g_state
        if (d == ND-1) begin : g_last
          always_ff @(posedge clk) begin
            if (rst)       st[l][d-1] <= '0;
            else if (fire) st[l][d-1] <= psum[l][d];
          end
        end else begin : g_mid
          always_ff @(posedge clk) begin
            if (rst)       st[l][d-1] <= '0;
            else if (fire) st[l][d-1] <= psum[l][d] + st[l][d];
          end
        end
      end
    end

    assign acc_o[l] = psum[l][0] + st[l][0];
  end
endmodule

// File: rtl/blkpoly_rndsat.sv
module blkpoly_rndsat #(
  parameter int AW   = 36,
  parameter int DW   = 16,
  parameter int FRAC = 14
) (
  input  logic signed [AW-1:0] acc_i,
  output logic signed [DW-1:0] res_o
);
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (FRAC - 1);
  localparam logic signed [AW-1:0] MAXV = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [AW-1:0] MINV = ~MAXV;

  logic signed [AW-1:0] shifted;

  always_comb begin
    shifted = (acc_i + HALF) >>> FRAC;
    if (shifted > MAXV)      res_o = MAXV[DW-1:0];
    else if (shifted < MINV) res_o = MINV[DW-1:0];
    else                     res_o = shifted[DW-1:0];
  end
endmodule

// File: rtl/blkpoly_serializer.sv
module blkpoly_serializer #(
  parameter int L  = 5,
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic signed [DW-1:0] lane_i [L],
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data
);
  localparam int RW = (L > 2) ? $clog2(L) : 1;

  logic signed [DW-1:0] hold [L-1];
  logic [RW-1:0]        rem;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      rem       <= '0;
      for (int j = 0; j < L-1; j++) hold[j] <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= lane_i[0];
      rem       <= RW'(L-1);
      for (int j = 0; j < L-1; j++) hold[j] <= lane_i[j+1];
    end else if (rem != '0) begin
      out_valid <= 1'b1;
      out_data  <= hold[0];
      rem       <= rem - 1'b1;
      for (int j = 0; j < L-2; j++) hold[j] <= hold[j+1];
      hold[L-2] <= '0;
    end else begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end
  end
endmodule

// File: rtl/blkpoly_interp.sv
module blkpoly_interp #(
  parameter int L     = 5,
  parameter int M     = 3,
  parameter int NTAPS = blkpoly_pkg::DEF_NTAPS,
  parameter int DW    = 16,
  parameter int CW    = blkpoly_pkg::DEF_CW,
  parameter int FRAC  = 14,
  parameter logic [NTAPS*CW-1:0] TAPS = blkpoly_pkg::default_taps()
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data
);
  localparam int AW = DW + CW + 4;

  logic                 fire;
  logic signed [DW-1:0] blk  [M];
  logic signed [AW-1:0] acc  [L];
  logic signed [DW-1:0] lane [L];

  blkpoly_blocker #(.M(M), .DW(DW)) u_blocker (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .blk_fire(fire), .blk_o(blk)
  );

  blkpoly_matrix #(
    .L(L), .M(M), .NTAPS(NTAPS), .DW(DW), .CW(CW), .AW(AW), .TAPS(TAPS)
  ) u_matrix (
    .clk(clk), .rst(rst), .fire(fire), .blk_i(blk), .acc_o(acc)
  );

  for (genvar l = 0; l < L; l++) begin : g_lane
    blkpoly_rndsat #(.AW(AW), .DW(DW), .FRAC(FRAC)) u_rs (
      .acc_i(acc[l]), .res_o(lane[l])
    );
  end

  blkpoly_serializer #(.L(L), .DW(DW)) u_ser (
    .clk(clk), .rst(rst), .load(fire), .lane_i(lane),
    .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: rtl/blkpoly_interp_chk.sv
module blkpoly_interp_chk #(
  parameter int L  = 5,
  parameter int M  = 3,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          out_valid,
  input logic [DW-1:0] out_data
);
  localparam int CNW = (M > 2) ? $clog2(M) : 1;
  localparam int LW  = $clog2(L + 1);

  logic [CNW-1:0] cnt;
  logic [LW-1:0]  left;

  // Independent tally of accepted samples and owed outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      left <= '0;
    end else begin
      if (in_valid) cnt <= (cnt == CNW'(M-1)) ? '0 : cnt + 1'b1;
      if (in_valid && cnt == CNW'(M-1)) left <= LW'(L);
      else if (left != '0)              left <= left - 1'b1;
    end
  end

  p_idle_zero_r1: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> out_data == '0);

  // R2 / R7 / R9: exactly L valid cycles owed per completed block
  p_owed_valid_r2: assert property (@(posedge clk) disable iff (rst)
    (left != '0) |-> out_valid);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
    (left == '0) |-> !out_valid);

  p_idle_no_start_r4: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !$rose(out_valid));
endmodule

bind blkpoly_interp blkpoly_interp_chk #(.L(L), .M(M), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/blkpoly_interp_tb.sv
`timescale 1ns/1ps
module blkpoly_interp_tb;
  localparam int NT = 23;
  localparam int CWB = 16;

  function automatic logic [NT*CWB-1:0] tb_taps();
    logic [NT*CWB-1:0] r;
    r = '0;
    for (int k = 0; k < NT; k++) r[k*CWB +: CWB] = CWB'(8000 - 40 * (k - 11) * (k - 11));
    return r;
  endfunction

  localparam logic [NT*CWB-1:0] TB_TAPS = tb_taps();

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] in_data = '0;
  logic out_valid;
  logic signed [15:0] out_data;

  always #5 clk = ~clk;

  blkpoly_interp #(.TAPS(TB_TAPS)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R1";
  int xs[$];
  int q[$];
  int since = 5;
  int lfsr = 32'h1ACE;

  function automatic int tapv(int j);
    return 8000 - 40 * (j - 11) * (j - 11);
  endfunction

  function automatic int rnd_sat(longint acc);
    longint r;
    r = (acc + 64'sd8192) >>> 14;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic block_done();
    int k;
    k = xs.size() / 3 - 1;
    for (int l = 0; l < 5; l++) begin
      longint acc = 0;
      for (int i = 0; i < xs.size(); i++) begin
        int idx = 15 * k + 3 * l - 5 * i;
        if (idx >= 0 && idx < NT) acc += longint'(xs[i]) * tapv(idx);
      end
      q.push_back(rnd_sat(acc));
    end
  endtask

  task automatic tick(bit v, int x, bit r);
    int ev, ed;
    @(negedge clk);
    ev = (q.size() > 0) ? 1 : 0;
    ed = ev ? q[0] : 0;
    checks++;
    if (out_valid !== ev[0] || int'(out_data) != ed) begin
      errors++;
      $display("FAIL %s: valid=%0b data=%0d expected valid=%0d data=%0d",
               cur_req, out_valid, out_data, ev, ed);
    end
    if (ev != 0) void'(q.pop_front());
    rst = r;
    in_valid = v && !r;
    in_data = 16'(x);
    if (r) begin
      xs.delete();
      q.delete();
      since = 5;
    end else if (v) begin
      xs.push_back(x);
      if (xs.size() % 3 == 0) begin
        block_done();
        since = 0;
      end else since++;
    end else since++;
  endtask

  task automatic send(int x);
    while ((xs.size() % 3) == 2 && since < 4) tick(0, 0, 0);
    tick(1, x, 0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0);
  endtask

  function automatic int next_rand();
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
    return lfsr;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    @(posedge clk);
    tick(0, 0, 1);
    tick(0, 0, 0);
    // R1: reset state and idle zero
    cur_req = "R1";
    idle(4);
    // R5: ties at centre tap, 128*8000/16384 = 62.5 -> 63, -62.5 -> -62
    cur_req = "R5";
    send(0); send(0); send(128);
    for (int i = 0; i < 9; i++) begin send(0); idle(1); end
    send(0); send(0); send(-128);
    for (int i = 0; i < 9; i++) begin send(0); idle(1); end
    idle(6);
    // R3 / R7: mixed values, irregular gaps
    cur_req = "R3";
    for (int i = 0; i < 60; i++) begin
      send((next_rand() % 20000) - 10000);
      idle(next_rand() % 4);
    end
    idle(8);
    // R4: long idle gaps do not disturb results
    cur_req = "R4";
    for (int i = 0; i < 12; i++) begin send((i * 2311) % 9000 - 4500); idle(11); end
    idle(8);
    // R9 / R2: back-to-back blocks at the maximum rate
    cur_req = "R9";
    for (int i = 0; i < 30; i++) send((next_rand() % 16000) - 8000);
    idle(8);
    // R6: full-scale runs saturate both ways
    cur_req = "R6";
    for (int i = 0; i < 24; i++) send(32767);
    for (int i = 0; i < 24; i++) send(-32768);
    for (int i = 0; i < 12; i++) send((i % 2) ? 32767 : -32768);
    idle(8);
    // R8: reset in the middle of a block
    cur_req = "R8";
    send(9000); send(-7000);
    tick(0, 0, 1);
    tick(0, 0, 1);
    tick(0, 0, 0);
    for (int i = 0; i < 9; i++) send(1000 * i - 3000);
    cur_req = "R2";
    idle(10);
    finish_run();
  end
endmodule